// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block turns the four sleep-control bits of a processor status word into an operating mode. From that mode it drives the enables for the CPU clock, the main clock, the auxiliary clock, the sub-system clock, the shared oscillator and the oscillator bias. It also drives a regulator enable and a real-time-clock keep-alive enable for the deepest, retention-free state.

Peripherals can ask for the auxiliary clock or the sub-system clock at any time. Such a request moves the requested sleep mode to a shallower actual mode, following a fixed mapping. The actual mode is reported on a 3-bit code, and every enable comes from a register on the free-running reference clock.

The status word is held in a local register. Software loads it with a strobe, and a wake event clears it, so the block returns to active mode. Status patterns that the mode table does not define fall back to the nearest shallower mode and raise a flag.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: The held status `sr_q` = {bit3 clock-group-1 off, bit2 clock-group-0 off, bit1 oscillator off, bit0 CPU off} decodes as follows, when no clock request is present and `reg_off`=0: 0000 gives active (`act_mode`=0), 0001 gives sleep 0 (1), 0101 gives sleep 1 (2), 1001 gives sleep 2 (3), 1101 gives sleep 3 (4) and 1111 gives sleep 4 (5).
- R2: Any other status pattern sets `mode_undef`=1 and maps to a shallower mode. With bit0=0 it maps to active. With bit0=1 it ignores bit1 and decodes bits 3:2 as for the defined sleep codes. For defined patterns `mode_undef`=0.
- R3: In active mode, `cpu_clk_en`, `main_clk_en` and `aux_clk_en` are 1, and `sub_clk_en` equals the inverse of `subclk_off`.
- R4: In sleep 0 and sleep 1, the CPU and main clock enables are 0, `aux_clk_en` is 1, and `sub_clk_en` equals the inverse of `subclk_off`.
- R5: In sleep 2 and sleep 3, only `aux_clk_en` is 1 among the clock enables. In sleep 4 all clock, oscillator and bias enables are 0.
- R6: `osc_en` follows the mode. In active mode it is `src_aux | src_main | (src_sub & ~subclk_off)`. In sleep 0 and 1 it is `src_aux | (src_sub & ~subclk_off)`. In sleep 2 and 3 it is `src_aux`. Otherwise it is 0.
- R7: `osc_bias_en` follows the mode. In active mode and in sleep 0 and 1 it is `osc_en | src_main | (src_sub & ~subclk_off)`. In sleep 2 and 3 it equals `osc_en`. Otherwise it is 0.
- R8: With an auxiliary request (any bit of `req_aux`) and no sub-system request, only a requested sleep 4 changes: it becomes sleep 3.
- R9: Any bit of `req_sub` promotes the requested mode as follows: sleep 2 becomes sleep 0, and sleep 3 or sleep 4 becomes sleep 1. Active, sleep 0 and sleep 1 are unchanged. The sub-system request overrides an auxiliary request.
- R10: A requested sleep 4 with `reg_off`=1 and no clock request enters the retention-free state (`act_mode`=6). In that state `reg_en`=0 and all clock, oscillator and bias enables are 0. `rtc_en` equals `rtc_keep` when parameter ALLOW_RTC=1 and is 0 otherwise. In every other mode `reg_en`=1 and `rtc_en`=0.
- R11: A `wake` pulse clears `sr_q` to 0000 on the next edge and takes priority over `sr_load`. As a result the outputs return to active mode.
- R12: `sr_load` captures `sr_in` on an edge, and every output is registered one edge after `sr_q` and the other inputs. Reset holds the following values: `sr_q`=0, `act_mode`=0, CPU/main/auxiliary/sub-system enables 1, `osc_en`=`osc_bias_en`=0, `reg_en`=1, `rtc_en`=0 and `mode_undef`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_in | input | 4 | Status word to load |
| sr_load | input | 1 | Load strobe for `sr_in` |
| wake | input | 1 | Wake event, clears held status |
| subclk_off | input | 1 | Sub-system clock off control |
| src_aux | input | 1 | Oscillator sources auxiliary clock |
| src_main | input | 1 | Oscillator sources main clock |
| src_sub | input | 1 | Oscillator sources sub-system clock |
| req_aux | input | N_AUX_REQ | Peripheral auxiliary-clock requests |
| req_sub | input | N_SUB_REQ | Peripheral sub-system-clock requests |
| reg_off | input | 1 | Allow regulator shutdown in sleep 4 |
| rtc_keep | input | 1 | Keep real-time clock alive when off |
| sr_q | output | 4 | Held status word |
| cpu_clk_en | output | 1 | CPU clock enable |
| main_clk_en | output | 1 | Main clock enable |
| aux_clk_en | output | 1 | Auxiliary clock enable |
| sub_clk_en | output | 1 | Sub-system clock enable |
| osc_en | output | 1 | Oscillator enable |
| osc_bias_en | output | 1 | Oscillator bias enable |
| reg_en | output | 1 | Regulator enable |
| rtc_en | output | 1 | Real-time clock keep-alive enable |
| act_mode | output | 3 | Actual mode code |
| mode_undef | output | 1 | Status pattern was undefined |

## Verification
If the held status register is corrupted, `sr_q` shows it at once. The mode code and every enable then show the wrong mode one edge later. A wrong decode or a missed promotion appears two edges after the load as a wrong `act_mode` and a wrong combination of clock enables. A bad oscillator rule appears only under a particular mix of source flags and `subclk_off`, which is why many random source combinations are checked in every mode.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int SR_W   = 4;
  localparam int MODE_W = 3;

  // status bit positions
  localparam int B_CPU  = 0;
  localparam int B_OSC  = 1;
  localparam int B_GRP0 = 2;
  localparam int B_GRP1 = 3;

  typedef enum logic [MODE_W-1:0] {
    M_ACT = 3'd0,
    M_S0  = 3'd1,
    M_S1  = 3'd2,
    M_S2  = 3'd3,
    M_S3  = 3'd4,
    M_S4  = 3'd5,
    M_OFF = 3'd6
  } mode_t;

  typedef struct packed {
    logic cpu;
    logic main;
    logic aux;
    logic sub;
    logic osc;
    logic bias;
    logic reg_on;
    logic rtc;
  } gate_t;

  localparam gate_t GATE_RESET = '{cpu: 1'b1, main: 1'b1, aux: 1'b1, sub: 1'b1,
                                   osc: 1'b0, bias: 1'b0, reg_on: 1'b1, rtc: 1'b0};
endpackage

// File: rtl/lpm_status_reg.sv
module lpm_status_reg #(
  parameter int W = lpm_pkg::SR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         wake,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wake) begin
      q <= '0;
    end else if (load) begin
      q <= din;
    end
  end

  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wake |=> (q == '0)); // R11
endmodule

// File: rtl/lpm_mode_decode.sv
module lpm_mode_decode
  import lpm_pkg::*;
#(
  parameter int W = SR_W
) (
  input  logic [W-1:0] sr,
  output mode_t        req_mode,
  output logic         undef
);
  logic cpu_off, osc_off;
  logic [1:0] grp;

  assign cpu_off = sr[B_CPU];
  assign osc_off = sr[B_OSC];
  assign grp     = {sr[B_GRP1], sr[B_GRP0]};

  always_comb begin
    req_mode = M_ACT;
    undef    = 1'b0;
    if (!cpu_off) begin
      // CPU running: anything else set is not a defined pattern
      req_mode = M_ACT;
      undef    = (grp != 2'b00) || osc_off;
    end else if (osc_off && (grp == 2'b11)) begin
      req_mode = M_S4;
    end else begin
      undef = osc_off;
      case (grp)
        2'b00:   req_mode = M_S0;
        2'b01:   req_mode = M_S1;
        2'b10:   req_mode = M_S2;
        default: req_mode = M_S3;
      endcase
    end
  end
endmodule

// File: rtl/lpm_req_promote.sv
module lpm_req_promote
  import lpm_pkg::*;
#(
  parameter int N_AUX = 2,
  parameter int N_SUB = 2
) (
  input  mode_t            req_mode,
  input  logic [N_AUX-1:0] req_aux,
  input  logic [N_SUB-1:0] req_sub,
  input  logic             reg_off,
  output mode_t            eff_mode
);
  logic any_aux, any_sub;

  assign any_aux = |req_aux;
  assign any_sub = |req_sub;

  always_comb begin
    eff_mode = req_mode;
    if (any_sub) begin
      case (req_mode)
        M_S2:       eff_mode = M_S0;
        M_S3, M_S4: eff_mode = M_S1;
        default:    eff_mode = req_mode;
      endcase
    end else if (any_aux) begin
      if (req_mode == M_S4) eff_mode = M_S3;
    end else if ((req_mode == M_S4) && reg_off) begin
      eff_mode = M_OFF;
    end
  end
endmodule

// File: rtl/lpm_gate_gen.sv
module lpm_gate_gen
  import lpm_pkg::*;
#(
  parameter bit ALLOW_RTC = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  mode_t eff_mode,
  input  logic  undef_in,
  input  logic  subclk_off,
  input  logic  src_aux,
  input  logic  src_main,
  input  logic  src_sub,
  input  logic  rtc_keep,
  output gate_t gate_q,
  output mode_t mode_q,
  output logic  undef_q
);
  gate_t g;
  logic  sub_live;
  logic  rtc_allowed;

  assign sub_live = ~subclk_off;

  generate
    if (ALLOW_RTC) begin : g_rtc
      assign rtc_allowed = rtc_keep;
    end else begin : g_nortc
      assign rtc_allowed = 1'b0;
    end
  endgenerate

  always_comb begin
    g = '{cpu: 1'b0, main: 1'b0, aux: 1'b0, sub: 1'b0,
          osc: 1'b0, bias: 1'b0, reg_on: 1'b1, rtc: 1'b0};
    case (eff_mode)
      M_ACT: begin
        g.cpu  = 1'b1;
        g.main = 1'b1;
        g.aux  = 1'b1;
        g.sub  = sub_live;
        g.osc  = src_aux | src_main | (src_sub & sub_live);
        g.bias = g.osc | src_main | (src_sub & sub_live);
      end
      M_S0, M_S1: begin
        g.aux  = 1'b1;
        g.sub  = sub_live;
        g.osc  = src_aux | (src_sub & sub_live);
        g.bias = g.osc | src_main | (src_sub & sub_live);
      end
      M_S2, M_S3: begin
        g.aux  = 1'b1;
        g.osc  = src_aux;
        g.bias = g.osc;
      end
      M_OFF: begin
        g.reg_on = 1'b0;
        g.rtc    = rtc_allowed;
      end
      default: begin
        g.reg_on = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= GATE_RESET;
      mode_q  <= M_ACT;
      undef_q <= 1'b0;
    end else begin
      gate_q  <= g;
      mode_q  <= eff_mode;
      undef_q <= undef_in;
    end
  end

  AST_REGOFF_ALL_STOP: assert property (@(posedge clk) disable iff (rst)
    !gate_q.reg_on |-> !(gate_q.cpu | gate_q.main | gate_q.aux | gate_q.sub | gate_q.osc)); // R10
endmodule

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl
  import lpm_pkg::*;
#(
  parameter int N_AUX_REQ = 2,
  parameter int N_SUB_REQ = 2,
  parameter bit ALLOW_RTC = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SR_W-1:0]      sr_in,
  input  logic                 sr_load,
  input  logic                 wake,
  input  logic                 subclk_off,
  input  logic                 src_aux,
  input  logic                 src_main,
  input  logic                 src_sub,
  input  logic [N_AUX_REQ-1:0] req_aux,
  input  logic [N_SUB_REQ-1:0] req_sub,
  input  logic                 reg_off,
  input  logic                 rtc_keep,
  output logic [SR_W-1:0]      sr_q,
  output logic                 cpu_clk_en,
  output logic                 main_clk_en,
  output logic                 aux_clk_en,
  output logic                 sub_clk_en,
  output logic                 osc_en,
  output logic                 osc_bias_en,
  output logic                 reg_en,
  output logic                 rtc_en,
  output logic [MODE_W-1:0]    act_mode,
  output logic                 mode_undef
);
  mode_t req_mode, eff_mode, mode_q;
  logic  undef_c;
  gate_t gate_q;

  lpm_status_reg #(.W(SR_W)) u_sr (
    .clk(clk), .rst(rst), .load(sr_load), .din(sr_in), .wake(wake), .q(sr_q)
  );

  lpm_mode_decode #(.W(SR_W)) u_dec (
    .sr(sr_q), .req_mode(req_mode), .undef(undef_c)
  );

  lpm_req_promote #(.N_AUX(N_AUX_REQ), .N_SUB(N_SUB_REQ)) u_prom (
    .req_mode(req_mode), .req_aux(req_aux), .req_sub(req_sub),
    .reg_off(reg_off), .eff_mode(eff_mode)
  );

  lpm_gate_gen #(.ALLOW_RTC(ALLOW_RTC)) u_gate (
    .clk(clk), .rst(rst), .eff_mode(eff_mode), .undef_in(undef_c),
    .subclk_off(subclk_off), .src_aux(src_aux), .src_main(src_main),
    .src_sub(src_sub), .rtc_keep(rtc_keep),
    .gate_q(gate_q), .mode_q(mode_q), .undef_q(mode_undef)
  );

  assign cpu_clk_en  = gate_q.cpu;
  assign main_clk_en = gate_q.main;
  assign aux_clk_en  = gate_q.aux;
  assign sub_clk_en  = gate_q.sub;
  assign osc_en      = gate_q.osc;
  assign osc_bias_en = gate_q.bias;
  assign reg_en      = gate_q.reg_on;
  assign rtc_en      = gate_q.rtc;
  assign act_mode    = mode_q;

  AST_CPU_NEEDS_AUX: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> aux_clk_en); // R3

  AST_PROMOTE_SHALLOW: assert property (@(posedge clk) disable iff (rst)
    (eff_mode <= req_mode) || ((eff_mode == M_OFF) && (req_mode == M_S4))); // R9

  AST_SUBREQ_KEEPS_SUB: assert property (@(posedge clk) disable iff (rst)
    ((|req_sub) && !subclk_off) |=> sub_clk_en); // R9

  AST_AUXREQ_KEEPS_AUX: assert property (@(posedge clk) disable iff (rst)
    (|req_aux) |=> aux_clk_en); // R8
endmodule

// File: tb/lpm_clock_ctrl_test.sv
module lpm_clock_ctrl_test;
  localparam int NA = 2;
  localparam int NS = 2;
  localparam bit RTC = 1'b1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] sr_in = '0;
  logic sr_load = 0, wake = 0, subclk_off = 0;
  logic src_aux = 0, src_main = 0, src_sub = 0;
  logic [NA-1:0] req_aux = '0;
  logic [NS-1:0] req_sub = '0;
  logic reg_off = 0, rtc_keep = 0;
  logic [3:0] sr_q;
  logic cpu_clk_en, main_clk_en, aux_clk_en, sub_clk_en, osc_en, osc_bias_en, reg_en, rtc_en;
  logic [2:0] act_mode;
  logic mode_undef;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk; // 50 MHz

  lpm_clock_ctrl #(.N_AUX_REQ(NA), .N_SUB_REQ(NS), .ALLOW_RTC(RTC)) uut (
    .clk(clk), .rst(rst), .sr_in(sr_in), .sr_load(sr_load), .wake(wake),
    .subclk_off(subclk_off), .src_aux(src_aux), .src_main(src_main), .src_sub(src_sub),
    .req_aux(req_aux), .req_sub(req_sub), .reg_off(reg_off), .rtc_keep(rtc_keep),
    .sr_q(sr_q), .cpu_clk_en(cpu_clk_en), .main_clk_en(main_clk_en),
    .aux_clk_en(aux_clk_en), .sub_clk_en(sub_clk_en), .osc_en(osc_en),
    .osc_bias_en(osc_bias_en), .reg_en(reg_en), .rtc_en(rtc_en),
    .act_mode(act_mode), .mode_undef(mode_undef)
  );

  // requested mode from status bits {g1,g0,osc,cpu}
  function automatic logic [3:0] ref_req(input logic [3:0] s);
    logic [2:0] m; logic u;
    case (s)
      4'b0000: begin m = 0; u = 0; end
      4'b0001: begin m = 1; u = 0; end
      4'b0101: begin m = 2; u = 0; end
      4'b1001: begin m = 3; u = 0; end
      4'b1101: begin m = 4; u = 0; end
      4'b1111: begin m = 5; u = 0; end
      default: begin
        u = 1;
        if (!s[0]) m = 0;
        else m = 3'(s[3:2]) + 3'd1;
      end
    endcase
    return {u, m};
  endfunction

  function automatic logic [2:0] ref_eff(input logic [2:0] m, input logic a, input logic b,
                                         input logic roff);
    if (b) begin
      if (m == 3) return 1;
      if (m == 4 || m == 5) return 2;
      return m;
    end
    if (a) return (m == 5) ? 3'd4 : m;
    if (m == 5 && roff) return 6;
    return m;
  endfunction

  // packed: cpu main aux sub osc bias reg rtc mode[2:0] undef
  function automatic logic [11:0] ref_out(input logic [3:0] s);
    logic [3:0] r; logic [2:0] e; logic c, mn, ax, sb, o, bi, rg, rt, live;
    r = ref_req(s);
    e = ref_eff(r[2:0], |req_aux, |req_sub, reg_off);
    live = ~subclk_off;
    {c, mn, ax, sb, o, bi, rt} = '0; rg = 1;
    if (e == 0) begin
      c = 1; mn = 1; ax = 1; sb = live;
      o = src_aux | src_main | (src_sub & live);
      bi = o | src_main | (src_sub & live);
    end else if (e == 1 || e == 2) begin
      ax = 1; sb = live;
      o = src_aux | (src_sub & live);
      bi = o | src_main | (src_sub & live);
    end else if (e == 3 || e == 4) begin
      ax = 1; o = src_aux; bi = o;
    end else if (e == 6) begin
      rg = 0; rt = RTC & rtc_keep;
    end
    return {c, mn, ax, sb, o, bi, rg, rt, e, r[3]};
  endfunction

  function automatic string tag_for(input logic [3:0] s);
    logic [3:0] r; logic [2:0] e;
    r = ref_req(s);
    e = ref_eff(r[2:0], |req_aux, |req_sub, reg_off);
    if (r[3]) return "R2";
    if (e == 6) return "R10";
    if (|req_sub && e != r[2:0]) return "R9";
    if (|req_aux && e != r[2:0]) return "R8";
    case (e)
      0: return "R3";
      1, 2: return "R4";
      3, 4: return (src_aux || src_main) ? "R6" : "R5";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [11:0] dut_out();
    return {cpu_clk_en, main_clk_en, aux_clk_en, sub_clk_en, osc_en, osc_bias_en,
            reg_en, rtc_en, act_mode, mode_undef};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // load status, hold other inputs, sample two edges later
  task automatic apply(input logic [3:0] s);
    @(negedge clk);
    sr_in = s; sr_load = 1;
    @(negedge clk);
    sr_load = 0;
    check("R12", {12'd0, sr_q}, {12'd0, s});
    @(negedge clk);
    check(tag_for(s), {4'd0, dut_out()}, {4'd0, ref_out(s)});
  endtask

  task automatic set_side(input logic [8:0] v);
    {subclk_off, src_aux, src_main, src_sub, reg_off, rtc_keep} = v[5:0];
    req_aux = NA'(v[7:6] & {2{v[8]}});
    req_sub = '0;
  endtask

  initial begin
    #4000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] codes [6];
    int unsigned seed;
    codes = '{4'b0000, 4'b0001, 4'b0101, 4'b1001, 4'b1101, 4'b1111};
    seed = $urandom(32'h1C0DE);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    check("R12", {4'd0, dut_out()}, {4'd0, 12'b1111_0010_000_0});
    check("R12", {12'd0, sr_q}, 16'd0);
    rst = 0;

    // R1 defined codes, quiet side inputs
    for (int i = 0; i < 6; i++) begin
      apply(codes[i]);
      check("R1", {13'd0, act_mode}, {13'd0, 3'(i)});
    end

    // R6 R7 oscillator in active and sleep 0 with sub running
    src_main = 1; apply(4'b0000);
    check("R6", {15'd0, osc_en}, 16'd1);
    src_main = 0; src_sub = 1; apply(4'b0001);
    check("R7", {15'd0, osc_bias_en}, 16'd1);
    subclk_off = 1; apply(4'b0001);
    check("R6", {15'd0, osc_en}, 16'd0);
    subclk_off = 0; src_sub = 0; src_main = 1; apply(4'b0001);
    check("R7", {14'd0, osc_en, osc_bias_en}, 16'b01);
    src_main = 0;

    // R8 aux request on sleep 4 and sleep 2
    req_aux = 2'b10; apply(4'b1111);
    check("R8", {13'd0, act_mode}, 16'd4);
    apply(4'b1001);
    check("R8", {13'd0, act_mode}, 16'd3);
    // R9 sub request overrides
    req_sub = 2'b01; apply(4'b1111);
    check("R9", {13'd0, act_mode}, 16'd2);
    req_aux = '0; apply(4'b1001);
    check("R9", {13'd0, act_mode}, 16'd1);
    apply(4'b0101);
    check("R9", {13'd0, act_mode}, 16'd2);
    req_sub = '0;

    // R10 retention-free state
    reg_off = 1; rtc_keep = 1; apply(4'b1111);
    check("R10", {13'd0, act_mode}, 16'd6);
    check("R10", {14'd0, reg_en, rtc_en}, 16'b01);
    rtc_keep = 0; apply(4'b1111);
    check("R10", {15'd0, rtc_en}, 16'd0);
    req_sub = 2'b10; apply(4'b1111);
    check("R10", {15'd0, reg_en}, 16'd1);
    req_sub = '0; reg_off = 0;

    // R2 undefined patterns
    apply(4'b0011);
    check("R2", {12'd0, act_mode, mode_undef}, {12'd0, 3'd1, 1'b1});
    apply(4'b1110);
    check("R2", {12'd0, act_mode, mode_undef}, {12'd0, 3'd0, 1'b1});

    // R11 wake clears held status, beats load
    apply(4'b1101);
    @(negedge clk); wake = 1; sr_in = 4'b1111; sr_load = 1;
    @(negedge clk); wake = 0; sr_load = 0;
    check("R11", {12'd0, sr_q}, 16'd0);
    @(negedge clk);
    check("R11", {13'd0, act_mode}, 16'd0);
    check("R11", {4'd0, dut_out()}, {4'd0, ref_out(4'b0000)});

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [3:0] s;
      logic [8:0] side;
      side = 9'($urandom());
      set_side(side);
      if ($urandom() % 4 == 0) req_sub = NS'($urandom());
      if ($urandom() % 5 == 0) s = 4'($urandom());
      else s = codes[$urandom() % 6];
      apply(s);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule